// File: doc/BRIEF.md
# Delayed-Branch Condition and Delay-Slot Squash Resolver

This block sits beside the decode and execute logic of a processor pipeline that uses delayed branches. For each branch presented to it, the block takes the current integer flags (negative, zero, overflow, carry), a 4-bit condition code, an annul bit and a selector between the integer and floating-point branch families. For a floating-point branch it also takes a 2-bit comparison state. The block reports two things: whether the branch is taken, and whether the instruction in the delay slot must be squashed.

The result is registered. A request presented on one rising clock edge appears on the outputs after that edge and stays there for one cycle. Both condition families share one encoding rule: bit 3 of the condition code inverts the sense of the condition named by bits 2:0. The squash rule depends on two things. The first is whether the condition held. The second is whether the condition is unconditional, meaning code 0 ("never") or code 8 ("always").

Top module: `branch_resolve`

## Requirements
- R1: While rst_n is low, and on the first cycle after it goes high, valid_o, taken_o and squash_o are all 0.
- R2: The outputs have a latency of one clock. valid_o equals the valid_i sampled at the previous edge. When that sample was 0, taken_o and squash_o are 0 whatever the other inputs were.
- R3: With fp_sel_i = 0, condition codes 0 to 15 mean the following: never, equal (Z), less-or-equal (Z|(N^V)), less (N^V), unsigned less-or-equal (C|Z), carry set (C), negative (N), overflow set (V), always, not equal, greater, greater-or-equal, unsigned greater, carry clear, positive and overflow clear. Code 8+k is the complement of code k.
- R4: The signed conditions evaluate as follows: greater is !(Z|(N^V)), less is N^V, and greater-or-equal is !(N^V).
- R5: The unsigned conditions evaluate as follows: unsigned greater is !(C|Z). Carry clear (code 13) is taken exactly when C=0, which is unsigned greater-or-equal. Carry set (code 5) is taken exactly when C=1, which is unsigned less.
- R6: With fp_sel_i = 1, fcmp_i encodes the comparison as 0 = equal, 1 = less, 2 = greater, 3 = unordered. Codes 0 to 7 are taken for these outcome sets: {}, {U,L,G}, {L,G}, {U,L}, {L}, {U,G}, {G}, {U}. Code 8+k is taken for the complementary set.
- R7: The unordered state (fcmp_i = 3) takes only codes whose set includes U. Codes 7, 3 and 5 are taken. Codes 15 (ordered), 2 and 9 (equal) are not taken.
- R8: When annul_i = 1, a conditional branch (condition bits 2:0 not 0) that is not taken sets squash_o.
- R9: A conditional branch that is taken never sets squash_o, whatever annul_i is.
- R10: When annul_i = 1, codes 0 and 8 set squash_o in both families, even though code 8 is taken.
- R11: When annul_i = 0, squash_o is 0 for every code and every flag value.
- R12: With fp_sel_i = 1 the integer flags have no effect. With fp_sel_i = 0 fcmp_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | A branch is presented this cycle |
| fp_sel_i | input | 1 | 1 = floating-point branch family, 0 = integer |
| cond_i | input | 4 | Condition code |
| annul_i | input | 1 | Annul bit of the branch |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| fcmp_i | input | 2 | Floating comparison state |
| valid_o | output | 1 | Registered copy of valid_i |
| taken_o | output | 1 | The branch is taken |
| squash_o | output | 1 | The delay-slot instruction must be squashed |

## Verification
The bench sweeps every integer condition across all 16 flag combinations, and every floating condition across all four comparison states, each with the annul bit clear and set. This exposes a swapped signed and unsigned test, or a carry sense that is inverted. It also catches an unordered state that leaks into "ordered" or "equal". Code 8 with annul set is the sharpest case: a design that squashes only on not-taken would let that delay slot execute. A design that ignores the taken outcome would squash the slots of taken conditional branches. Idle cycles, and foreign inputs toggled at random, show whether a result leaks when valid_i is low or when the other family's inputs change.

// File: rtl/brx_pkg.sv
package brx_pkg;
    localparam int CODE_W = 4;
    localparam int FCMP_W = 2;

    typedef enum logic [FCMP_W-1:0] {
        FC_EQ = 2'd0,
        FC_LT = 2'd1,
        FC_GT = 2'd2,
        FC_UN = 2'd3
    } fcmp_e;

    typedef struct packed {
        logic valid;
        logic taken;
        logic squash;
    } br_res_t;
endpackage

// File: rtl/int_cond_eval.sv
module int_cond_eval
    import brx_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0] cond,
    input  logic          n,
    input  logic          z,
    input  logic          v,
    input  logic          c,
    output logic          hit
);
    localparam int SEL_W = CW - 1;

    logic base;
    logic lt_signed;

    always_comb begin
        lt_signed = n ^ v;
        unique case (cond[SEL_W-1:0])
            3'd0: base = 1'b0;
            3'd1: base = z;
            3'd2: base = z | lt_signed;
            3'd3: base = lt_signed;
            3'd4: base = c | z;
            3'd5: base = c;
            3'd6: base = n;
            default: base = v;
        endcase
        hit = base ^ cond[CW-1];
    end
endmodule

// File: rtl/fp_cond_eval.sv
module fp_cond_eval
    import brx_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0]     cond,
    input  logic [FCMP_W-1:0] fcmp,
    output logic              hit
);
    localparam int SEL_W  = CW - 1;
    localparam int N_OUTC = 1 << FCMP_W;

    // mask bit i set: outcome i (0 eq, 1 lt, 2 gt, 3 unordered) satisfies the base condition
    logic [N_OUTC-1:0] mask;

    always_comb begin
        unique case (cond[SEL_W-1:0])
            3'd0: mask = 4'b0000;
            3'd1: mask = 4'b1110;
            3'd2: mask = 4'b0110;
            3'd3: mask = 4'b1010;
            3'd4: mask = 4'b0010;
            3'd5: mask = 4'b1100;
            3'd6: mask = 4'b0100;
            default: mask = 4'b1000;
        endcase
        hit = mask[fcmp] ^ cond[CW-1];
    end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import brx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              fp_sel_i,
    input  logic [CODE_W-1:0] cond_i,
    input  logic              annul_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_v_i,
    input  logic              flag_c_i,
    input  logic [FCMP_W-1:0] fcmp_i,
    output logic              valid_o,
    output logic              taken_o,
    output logic              squash_o
);
    localparam int SEL_W = CODE_W - 1;

    logic    int_hit;
    logic    fp_hit;
    logic    uncond;
    logic    hit;
    br_res_t res_d;
    br_res_t res_q;

    int_cond_eval #(.CW(CODE_W)) i_int (
        .cond (cond_i),
        .n    (flag_n_i),
        .z    (flag_z_i),
        .v    (flag_v_i),
        .c    (flag_c_i),
        .hit  (int_hit)
    );

    fp_cond_eval #(.CW(CODE_W)) i_fp (
        .cond (cond_i),
        .fcmp (fcmp_i),
        .hit  (fp_hit)
    );

    always_comb begin
        uncond       = (cond_i[SEL_W-1:0] == '0);
        hit          = fp_sel_i ? fp_hit : int_hit;
        res_d.valid  = valid_i;
        res_d.taken  = valid_i & hit;
        res_d.squash = valid_i & annul_i & (uncond | ~hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_o  = res_q.valid;
    assign taken_o  = res_q.taken;
    assign squash_o = res_q.squash;
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk
    import brx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              fp_sel_i,
    input logic [CODE_W-1:0] cond_i,
    input logic              annul_i,
    input logic              flag_z_i,
    input logic              flag_c_i,
    input logic [FCMP_W-1:0] fcmp_i,
    input logic              valid_o,
    input logic              taken_o,
    input logic              squash_o
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && !taken_o && !squash_o));

    p_never_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_i == 4'd0) |=> !taken_o);

    p_always_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_i == 4'd8) |=> (taken_o && (squash_o == $past(annul_i))));

    p_equal_follows_z_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !fp_sel_i && cond_i == 4'd1) |=> (taken_o == $past(flag_z_i)));

    p_carry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !fp_sel_i && cond_i == 4'd13) |=> (taken_o == !$past(flag_c_i)));

    p_unordered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fp_sel_i && fcmp_i == 2'd3 && cond_i == 4'd15) |=> !taken_o);

    p_taken_no_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cond_i[2:0] != 3'd0) && taken_o) |-> !squash_o);

    p_no_annul_no_squash_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !annul_i |=> !squash_o);

    p_not_taken_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && annul_i) |=> (taken_o || squash_o));
endmodule

bind branch_resolve branch_resolve_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .fp_sel_i (fp_sel_i),
    .cond_i   (cond_i),
    .annul_i  (annul_i),
    .flag_z_i (flag_z_i),
    .flag_c_i (flag_c_i),
    .fcmp_i   (fcmp_i),
    .valid_o  (valid_o),
    .taken_o  (taken_o),
    .squash_o (squash_o)
);

// File: tb/test_branch_resolve.sv
module test_branch_resolve;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic       fp_sel_i = 1'b0;
    logic [3:0] cond_i = '0;
    logic       annul_i = 1'b0;
    logic       flag_n_i = 1'b0;
    logic       flag_z_i = 1'b0;
    logic       flag_v_i = 1'b0;
    logic       flag_c_i = 1'b0;
    logic [1:0] fcmp_i = '0;
    logic       valid_o;
    logic       taken_o;
    logic       squash_o;

    int checks = 0;
    int fails  = 0;
    bit exp_v = 0, exp_t = 0, exp_s = 0;
    string exp_req = "R1";

    always #2.5 clk = ~clk;

    branch_resolve i_branch_resolve (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .fp_sel_i(fp_sel_i),
        .cond_i(cond_i), .annul_i(annul_i), .flag_n_i(flag_n_i),
        .flag_z_i(flag_z_i), .flag_v_i(flag_v_i), .flag_c_i(flag_c_i),
        .fcmp_i(fcmp_i), .valid_o(valid_o), .taken_o(taken_o), .squash_o(squash_o)
    );

    // Integer condition per R3/R4/R5, written from the named meanings
    function automatic bit int_ref(int code, bit n, bit z, bit v, bit c);
        case (code)
            0:  return 0;
            1:  return z;
            2:  return z || (n != v);
            3:  return n != v;
            4:  return c || z;
            5:  return c;
            6:  return n;
            7:  return v;
            8:  return 1;
            9:  return !z;
            10: return !z && (n == v);
            11: return n == v;
            12: return !c && !z;
            13: return !c;
            14: return !n;
            default: return !v;
        endcase
    endfunction

    // Floating condition per R6/R7: membership of outcome in the listed set
    function automatic bit fp_ref(int code, int outc);
        string sets [8] = '{"", "ULG", "LG", "UL", "L", "UG", "G", "U"};
        string letters = "ELGU";
        bit in_set = 0;
        string s = sets[code % 8];
        for (int i = 0; i < s.len(); i++)
            if (s[i] == letters[outc]) in_set = 1;
        return (code >= 8) ? !in_set : in_set;
    endfunction

    task automatic check(string what, bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b (cond=%0d fp=%0b)",
                     req, what, act, exp, cond_i, fp_sel_i);
        end
    endtask

    // Compare on every negedge against the prediction made one cycle earlier
    task automatic compare();
        check("valid_o", valid_o, exp_v, exp_v ? "R2" : exp_req);
        check("taken_o", taken_o, exp_t, exp_req);
        check("squash_o", squash_o, exp_s, exp_req);
    endtask

    task automatic apply(bit v, bit fp, int code, bit an, bit n, bit z, bit vv, bit c, int fc);
        bit hit, unc;
        @(negedge clk);
        compare();
        valid_i = v; fp_sel_i = fp; cond_i = 4'(code); annul_i = an;
        flag_n_i = n; flag_z_i = z; flag_v_i = vv; flag_c_i = c; fcmp_i = 2'(fc);
        hit = fp ? fp_ref(code, fc) : int_ref(code, n, z, vv, c);
        unc = (code % 8) == 0;
        exp_v = v;
        exp_t = v && hit;
        exp_s = v && an && (unc || !hit);
        if (!v) exp_req = "R2";
        else if (!an) exp_req = "R11";
        else if (unc) exp_req = "R10";
        else if (hit) exp_req = "R9";
        else exp_req = "R8";
        if (v && fp && fc == 3) exp_req = {exp_req, "/R7"};
        else if (v && fp) exp_req = {exp_req, "/R6"};
        else if (v) exp_req = {exp_req, "/R3"};
    endtask

    initial begin
        // R1: reset state, during and on the first cycle after release
        repeat (3) @(negedge clk);
        check("valid_o reset", valid_o, 0, "R1");
        check("taken_o reset", taken_o, 0, "R1");
        check("squash_o reset", squash_o, 0, "R1");
        valid_i = 1; cond_i = 4'd8;
        @(negedge clk);
        rst_n = 1;
        valid_i = 0;
        @(negedge clk);
        check("taken_o after reset", taken_o, 0, "R1");
        exp_v = 0; exp_t = 0; exp_s = 0; exp_req = "R1";

        // R3 R4 R5 R8 R9 R10 R11: full integer sweep
        for (int code = 0; code < 16; code++)
            for (int f = 0; f < 16; f++)
                for (int an = 0; an < 2; an++)
                    apply(1, 0, code, an[0], f[3], f[2], f[1], f[0], $urandom_range(0, 3));

        // R6 R7 R10 R12: floating sweep with integer flags toggled at random
        for (int code = 0; code < 16; code++)
            for (int fc = 0; fc < 4; fc++)
                for (int an = 0; an < 2; an++) begin
                    int r = $urandom_range(0, 15);
                    apply(1, 1, code, an[0], r[3], r[2], r[1], r[0], fc);
                end

        // R2: idle cycles with busy inputs, interleaved with live branches
        for (int k = 0; k < 60; k++) begin
            int r = $urandom_range(0, 255);
            apply(r[7] & r[6], r[5], $urandom_range(0, 15), r[4], r[3], r[2], r[1], r[0],
                  $urandom_range(0, 3));
        end

        apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule